// File: doc/BRIEF.md
# Pre-Trigger Capture Buffer

This block records byte-wide samples from one to three channels into a circular memory. It stays idle until a wake command arrives. Once awake, every sample strobe writes one byte per channel at the write pointer, and the pointer wraps so that the oldest entry is overwritten. A push-button trigger is synchronized and debounced inside the block. A debounced press starts a post-trigger phase. That phase accepts exactly three quarters of the buffer depth in further writes, so one quarter of the stored window comes from before the press.

When the post-trigger phase ends, capture freezes and the indicator stays lit. The stored window is then streamed out over a valid/ready byte port, oldest sample first. All of channel 0 is sent, then channel 1, and so on. When the downstream side accepts the final byte, the indicator goes dark and capture resumes with an empty window. The sample source, the button and the serial link are outside the block.

Top module: `pretrig_capture`

## Requirements
- R1: After reset the block is asleep: out_valid_o and trig_led_o are 0, and sample strobes write nothing.
- R2: A button press while asleep has no effect; trig_led_o stays 0 and no readout starts.
- R3: Once awake, each smp_valid_i writes one byte per channel at the next circular position, overwriting the oldest entry after DEPTH writes.
- R4: A trigger event occurs only when the synchronized button level is 1 and differs from the debounced level for DB_CYCLES consecutive cycles. Shorter pulses are ignored.
- R5: trig_led_o rises in the cycle after the trigger event. It stays 1 until readout completes. Exactly 3*DEPTH/4 further sample writes are taken before readout begins.
- R6: Readout per channel starts at the oldest stored entry, i.e. the write position at freeze time, and proceeds in write order, wrapping around the buffer.
- R7: An entry not written since the last wake or re-arm reads out as 0.
- R8: Readout sends DEPTH bytes of channel 0, then channel 1, up to channel NCH-1, where channel c is smp_data_i[8c+7:8c]. While out_valid_o is 1 and out_ready_i is 0, valid and data hold steady.
- R9: Sample strobes during readout do not alter the frozen contents.
- R10: In the cycle after the last byte is accepted, trig_led_o is 0 and capture resumes. A button still held from before does not retrigger until it is released and pressed again.
- R11: wake_i has no effect once the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake command pulse; enables capture |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | NCH*8 | One byte per channel, channel c at bits 8c+7:8c |
| trig_btn_i | input | 1 | Raw push-button level, asynchronous |
| trig_led_o | output | 1 | Triggered indicator |
| out_valid_o | output | 1 | Readout byte available |
| out_data_o | output | 8 | Readout byte |
| out_ready_i | input | 1 | Downstream accepts the byte |

## Verification
On every cycle, the assertions check the following:
- a sleeping block stays silent;
- the memory is never written during readout;
- a stalled byte holds;
- the indicator covers the whole readout;
- the write counter reads exactly three quarters of the depth when readout begins;
- the indicator falls only after a final handshake.

Other behaviours appear only through the bench scenarios:
- chronological ordering, and the zero fill of unwritten entries;
- channel sequencing;
- rejection of short button pulses;
- no retrigger from a held button after re-arm.

The bench checks these against a behavioural model that is compared on every clock.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;

   typedef enum logic [1:0] {
      CAP_SLEEP = 2'd0,
      CAP_RUN   = 2'd1,
      CAP_POST  = 2'd2,
      CAP_DUMP  = 2'd3
   } cap_state_e;

   localparam int unsigned SMP_W = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pretrig_trig_cond.sv
module pretrig_trig_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DB_CYCLES   = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_i,
   output logic press_o
);
   localparam int unsigned DBW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level;
   logic                   db_q;
   logic                   press_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
      end else begin
         sync_q[0] <= btn_i;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   generate
      if (DB_CYCLES > 1) begin : g_filter
         logic [DBW-1:0] cnt_q;
         logic           cnt_full;
         assign cnt_full = (cnt_q == DBW'(DB_CYCLES - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q   <= '0;
               db_q    <= 1'b0;
               press_q <= 1'b0;
            end else begin
               press_q <= level & ~db_q & cnt_full;
               if (level != db_q) begin
                  if (cnt_full) begin
                     db_q  <= level;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + DBW'(1);
                  end
               end else begin
                  cnt_q <= '0;
               end
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               db_q    <= 1'b0;
               press_q <= 1'b0;
            end else begin
               press_q <= level & ~db_q;
               db_q    <= level;
            end
         end
      end
   endgenerate

   assign press_o = press_q;

endmodule

// File: rtl/pretrig_store.sv
module pretrig_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned NCH   = 3
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic                                   clr_i,
   input  logic                                   we_i,
   input  logic [$clog2(DEPTH)-1:0]               waddr_i,
   input  logic [NCH*pretrig_pkg::SMP_W-1:0]      wdata_i,
   input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] rch_i,
   input  logic [$clog2(DEPTH)-1:0]               raddr_i,
   output logic [pretrig_pkg::SMP_W-1:0]          rdata_o
);
   import pretrig_pkg::*;

   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

   logic [DEPTH-1:0] filled_q;
   logic [SMP_W-1:0] lane_rd [NCH];
   logic [SMP_W-1:0] lane_sel;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         filled_q <= '0;
      end else if (clr_i) begin
         filled_q <= '0;
      end else if (we_i) begin
         filled_q[waddr_i] <= 1'b1;
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         logic [SMP_W-1:0] mem_q [DEPTH];
         always_ff @(posedge clk_i) begin
            if (we_i) begin
               mem_q[waddr_i] <= wdata_i[c*SMP_W +: SMP_W];
            end
         end
         assign lane_rd[c] = mem_q[raddr_i];
      end
   endgenerate

   always_comb begin
      lane_sel = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rch_i == CHW'(c)) begin
            lane_sel = lane_rd[c];
         end
      end
   end

   assign rdata_o = filled_q[raddr_i] ? lane_sel : '0;

endmodule

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
   import pretrig_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned NCH   = 3
) (
   input  logic                                     clk_i,
   input  logic                                     rst_ni,
   input  logic                                     wake_i,
   input  logic                                     smp_valid_i,
   input  logic                                     press_i,
   input  logic                                     out_ready_i,
   output logic                                     we_o,
   output logic [$clog2(DEPTH)-1:0]                 waddr_o,
   output logic                                     clr_o,
   output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] rch_o,
   output logic [$clog2(DEPTH)-1:0]                 raddr_o,
   output logic                                     out_valid_o,
   output logic                                     led_o,
   output cap_state_e                               state_o
);
   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned CHW    = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned POST_N = (3 * DEPTH) / 4;

   cap_state_e     st_q;
   logic [AW-1:0]  wp_q;
   logic [AW-1:0]  post_q;
   logic [AW-1:0]  rp_q;
   logic [AW-1:0]  rc_q;
   logic [CHW-1:0] ch_q;
   logic           ch_last;
   logic           hs;
   logic           rc_last;
   logic           post_done;
   logic           finish;

   assign we_o      = smp_valid_i && ((st_q == CAP_RUN) || (st_q == CAP_POST));
   assign hs        = (st_q == CAP_DUMP) && out_ready_i;
   assign rc_last   = (rc_q == AW'(DEPTH - 1));
   assign post_done = (st_q == CAP_POST) && we_o && (post_q == AW'(POST_N - 1));
   assign finish    = hs && rc_last && ch_last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= CAP_SLEEP;
         wp_q   <= '0;
         post_q <= '0;
         rp_q   <= '0;
         rc_q   <= '0;
      end else begin
         if (we_o) begin
            wp_q <= wp_q + AW'(1);
         end
         if (st_q == CAP_RUN) begin
            post_q <= '0;
         end else if ((st_q == CAP_POST) && we_o) begin
            post_q <= post_q + AW'(1);
         end
         if (post_done) begin
            rp_q <= wp_q + AW'(1);
            rc_q <= '0;
         end else if (hs) begin
            rp_q <= rp_q + AW'(1);
            rc_q <= rc_q + AW'(1);
         end
         unique case (st_q)
            CAP_SLEEP: if (wake_i)    st_q <= CAP_RUN;
            CAP_RUN:   if (press_i)   st_q <= CAP_POST;
            CAP_POST:  if (post_done) st_q <= CAP_DUMP;
            CAP_DUMP:  if (finish)    st_q <= CAP_RUN;
            default:                  st_q <= CAP_SLEEP;
         endcase
      end
   end

   generate
      if (NCH > 1) begin : g_multi_ch
         logic [CHW-1:0] chan_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chan_q <= '0;
            end else if (post_done) begin
               chan_q <= '0;
            end else if (hs && rc_last && !ch_last) begin
               chan_q <= chan_q + CHW'(1);
            end
         end
         assign ch_q    = chan_q;
         assign ch_last = (chan_q == CHW'(NCH - 1));
      end else begin : g_single_ch
         assign ch_q    = '0;
         assign ch_last = 1'b1;
      end
   endgenerate

   assign waddr_o     = wp_q;
   assign clr_o       = finish;
   assign rch_o       = ch_q;
   assign raddr_o     = rp_q;
   assign out_valid_o = (st_q == CAP_DUMP);
   assign led_o       = (st_q == CAP_POST) || (st_q == CAP_DUMP);
   assign state_o     = st_q;

endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
   import pretrig_pkg::*;
#(
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned NCH         = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DB_CYCLES   = 16
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wake_i,
   input  logic                 smp_valid_i,
   input  logic [NCH*SMP_W-1:0] smp_data_i,
   input  logic                 trig_btn_i,
   output logic                 trig_led_o,
   output logic                 out_valid_o,
   output logic [SMP_W-1:0]     out_data_o,
   input  logic                 out_ready_i
);
   localparam int unsigned AW  = $clog2(DEPTH);
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (!is_pow2(DEPTH) || (DEPTH < 4)) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 4");
      end
      if ((NCH < 1) || (NCH > 3)) begin : g_bad_nch
         $error("NCH must be 1 to 3");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DB_CYCLES < 1) begin : g_bad_db
         $error("DB_CYCLES must be at least 1");
      end
   endgenerate

   logic           press;
   logic           mem_we;
   logic [AW-1:0]  waddr;
   logic [AW-1:0]  raddr;
   logic [CHW-1:0] rch;
   logic           mem_clr;
   cap_state_e     cap_st;

   pretrig_trig_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .DB_CYCLES   (DB_CYCLES)
   ) u_trig (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .btn_i   (trig_btn_i),
      .press_o (press)
   );

   pretrig_ctrl #(
      .DEPTH (DEPTH),
      .NCH   (NCH)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wake_i      (wake_i),
      .smp_valid_i (smp_valid_i),
      .press_i     (press),
      .out_ready_i (out_ready_i),
      .we_o        (mem_we),
      .waddr_o     (waddr),
      .clr_o       (mem_clr),
      .rch_o       (rch),
      .raddr_o     (raddr),
      .out_valid_o (out_valid_o),
      .led_o       (trig_led_o),
      .state_o     (cap_st)
   );

   pretrig_store #(
      .DEPTH (DEPTH),
      .NCH   (NCH)
   ) u_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (mem_clr),
      .we_i    (mem_we),
      .waddr_i (waddr),
      .wdata_i (smp_data_i),
      .rch_i   (rch),
      .raddr_i (raddr),
      .rdata_o (out_data_o)
   );

endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk
   import pretrig_pkg::*;
#(
   parameter int unsigned DEPTH = 64
) (
   input logic             clk_i,
   input logic             rst_ni,
   input cap_state_e       state,
   input logic             we,
   input logic             out_valid_o,
   input logic             out_ready_i,
   input logic [SMP_W-1:0] out_data_o,
   input logic             trig_led_o
);
   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned POST_N = (3 * DEPTH) / 4;

   logic [AW:0] post_writes_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         post_writes_q <= '0;
      end else if (state == CAP_RUN) begin
         post_writes_q <= '0;
      end else if ((state == CAP_POST) && we) begin
         post_writes_q <= post_writes_q + (AW+1)'(1);
      end
   end

   // R1
   asleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == CAP_SLEEP) |-> (!out_valid_o && !trig_led_o && !we));

   // R5
   led_covers_dump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> trig_led_o);

   // R5
   post_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_valid_o) |-> (post_writes_q == (AW+1)'(POST_N)));

   // R8
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   // R9
   frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == CAP_DUMP) |-> !we);

   // R10
   rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(trig_led_o) |-> ($past(out_valid_o && out_ready_i) && (state == CAP_RUN)));

   // R11
   stay_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != CAP_SLEEP) |=> (state != CAP_SLEEP));

endmodule

bind pretrig_capture pretrig_capture_chk #(
   .DEPTH (DEPTH)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .state       (cap_st),
   .we          (mem_we),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_data_o  (out_data_o),
   .trig_led_o  (trig_led_o)
);

// File: tb/pretrig_capture_tb_top.sv
module pretrig_capture_tb_top;
   localparam int N   = 16;
   localparam int NC  = 3;
   localparam int DBC = 4;
   localparam int SS  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wake = 1'b0;
   logic          sv = 1'b0;
   logic          btn = 1'b0;
   logic          rdy = 1'b0;
   logic [NC*8-1:0] sd = '0;
   logic          led;
   logic          ov;
   logic [7:0]    od;

   int errs = 0;
   int checks = 0;
   int k = 0;
   int tick = 0;
   int got[$];

   always #2 clk = ~clk;

   pretrig_capture #(
      .DEPTH (N), .NCH (NC), .SYNC_STAGES (SS), .DB_CYCLES (DBC)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .wake_i (wake),
      .smp_valid_i (sv), .smp_data_i (sd), .trig_btn_i (btn),
      .trig_led_o (led), .out_valid_o (ov), .out_data_o (od),
      .out_ready_i (rdy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model: 0 sleep, 1 run, 2 post, 3 dump
   int m_st, m_wp, m_post, m_rp, m_rc, m_ch;
   int m_mem[NC][N];
   bit m_vld[N];
   int m_s[SS];
   int m_db, m_cnt, m_evt;

   always @(posedge clk) begin
      int lvl;
      int nev;
      bit w;
      if (!rst_n) begin
         m_st = 0; m_wp = 0; m_post = 0; m_rp = 0; m_rc = 0; m_ch = 0;
         m_db = 0; m_cnt = 0; m_evt = 0;
         for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
         for (int i = 0; i < SS; i++) m_s[i] = 0;
      end else begin
         w = sv && (m_st == 1 || m_st == 2);
         if (w) begin
            for (int c = 0; c < NC; c++) m_mem[c][m_wp] = int'((sd >> (8*c)) & 8'hFF);
            m_vld[m_wp] = 1'b1;
         end
         case (m_st)
            0: if (wake) m_st = 1;
            1: begin
               if (w) m_wp = (m_wp + 1) % N;
               if (m_evt != 0) begin m_st = 2; m_post = 0; end
            end
            2: if (w) begin
               m_wp = (m_wp + 1) % N;
               m_post++;
               if (m_post == 3*N/4) begin m_st = 3; m_rp = m_wp; m_rc = 0; m_ch = 0; end
            end
            default: if (rdy) begin
               m_rp = (m_rp + 1) % N;
               m_rc++;
               if (m_rc == N) begin
                  m_rc = 0;
                  m_ch++;
                  if (m_ch == NC) begin
                     m_st = 1;
                     for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
                  end
               end
            end
         endcase
         lvl = m_s[SS-1];
         nev = (lvl == 1 && m_db == 0 && m_cnt == DBC-1) ? 1 : 0;
         if (lvl != m_db) begin
            if (m_cnt == DBC-1) begin m_db = lvl; m_cnt = 0; end
            else m_cnt++;
         end else begin
            m_cnt = 0;
         end
         m_evt = nev;
         for (int i = SS-1; i > 0; i--) m_s[i] = m_s[i-1];
         m_s[0] = int'(btn);
      end
   end

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      int exp_d;
      if (rst_n) begin
         chk(led === (m_st >= 2), (m_st == 0) ? "R2 led while asleep" : "R5 led", int'(led), int'(m_st >= 2));
         chk(ov === (m_st == 3), (m_st == 0) ? "R1 valid while asleep" : "R8 valid", int'(ov), int'(m_st == 3));
         if (m_st == 3 && ov) begin
            exp_d = m_vld[m_rp] ? m_mem[m_ch][m_rp] : 0;
            chk(int'(od) == exp_d, "R6 readout byte", int'(od), exp_d);
            if (rdy) got.push_back(int'(od));
         end
      end
   end

   task automatic step(input bit feed, input bit b, input bit w);
      @(posedge clk);
      #1;
      tick++;
      sv   = feed;
      btn  = b;
      wake = w;
      rdy  = (tick % 4) != 3;
      if (feed) begin
         sd = {8'(k ^ 255), 8'(k + 100), 8'(k)};
         k++;
      end
   endtask

   initial begin
      #(4*150000);
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int guard;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(led == 1'b0, "R1 reset led", int'(led), 0);
      chk(ov == 1'b0, "R1 reset valid", int'(ov), 0);

      // asleep: samples and button presses ignored
      repeat (20) step(1, 1, 0);
      repeat (10) step(0, 0, 0);
      @(negedge clk);
      chk(led == 1'b0, "R2 press while asleep", int'(led), 0);
      chk(ov == 1'b0, "R1 no readout while asleep", int'(ov), 0);

      // wake, two pre-trigger samples, then an early trigger
      k = 0;
      step(0, 0, 1);
      repeat (2) step(1, 0, 0);
      repeat (10) step(0, 1, 0);
      @(negedge clk);
      chk(led == 1'b1, "R5 led after press", int'(led), 1);

      got.delete();
      guard = 0;
      while (got.size() < NC*N && guard < 2000) begin
         step(1, 1, (tick % 5) == 0);
         guard++;
      end
      @(negedge clk);
      chk(got.size() == NC*N, "R8 byte count", got.size(), NC*N);
      chk(led == 1'b0, "R10 led off after last byte", int'(led), 0);
      if (got.size() == NC*N) begin
         chk(got[0] == 0 && got[1] == 0, "R7 unwritten entries zero", got[0] + got[1], 0);
         for (int i = 2; i < N; i++)
            chk(got[i] == i-2, "R6 chronological channel 0", got[i], i-2);
         for (int i = 2; i < N; i++)
            chk(got[N+i] == i-2+100, "R8 channel 1 follows", got[N+i], i-2+100);
         for (int i = 2; i < N; i++)
            chk(got[2*N+i] == ((i-2) ^ 255), "R8 channel 2 last", got[2*N+i], (i-2) ^ 255);
      end

      // held button after re-arm must not retrigger
      repeat (30) step(1, 1, 0);
      @(negedge clk);
      chk(led == 1'b0, "R10 held button no retrigger", int'(led), 0);

      // short glitch rejected
      repeat (10) step(1, 0, 0);
      repeat (2) step(1, 1, 0);
      repeat (10) step(1, 0, 0);
      @(negedge clk);
      chk(led == 1'b0, "R4 short pulse ignored", int'(led), 0);

      // real press with the buffer fully overwritten
      got.delete();
      repeat (8) step(1, 1, 0);
      guard = 0;
      while (got.size() < NC*N && guard < 2000) begin
         step(1, 1, 0);
         guard++;
      end
      @(negedge clk);
      chk(got.size() == NC*N, "R8 second byte count", got.size(), NC*N);
      if (got.size() == NC*N) begin
         for (int i = 0; i < N-1; i++)
            chk(got[i+1] == ((got[i] + 1) & 255), "R3 circular overwrite order", got[i+1], (got[i] + 1) & 255);
      end
      repeat (5) step(0, 0, 0);
      @(negedge clk);
      chk(led == 1'b0 && ov == 1'b0, "R11 wake pulses left state intact", int'(led) + int'(ov), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule